// File: doc/BRIEF.md
# Dual-Mode Fractional/Integer Multiplier

This block is the multiply stage of a DSP datapath. Its main port takes two 16-bit operands. A signedness select for each operand widens it to 17 bits, so one 17x17 signed array serves signed, unsigned and mixed-sign products. A mode input picks one of two result formats. Fractional mode treats the operands as Q15 values and doubles the product to give a 1.31 result. Integer mode gives the plain product. Either result is sign-extended to a 40-bit accumulator width, so that a later stage can saturate it.

A second, independent port serves integer multiplies for the general-purpose register path. It accepts byte or word operands in any sign combination. A byte multiply uses the low 8 bits of each operand and returns a 16-bit result. A word multiply returns a 32-bit result. Each port registers its result on the clock edge at which its strobe is high, so the latency is one cycle, and it holds that result until its next strobe.

Top module: `dualmode_mul`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `acc_res`, `acc_vld`, `int_res` and `int_vld` are all zero.
- R2: `acc_vld` is high in exactly the cycle after each edge that samples `acc_go` high, and `acc_res` changes only on such edges.
- R3: When a sign select is 1, the operand is read as two's complement and bit 15 is its sign. When the sign select is 0, the operand is read as unsigned, in the range 0 to 65535. A product of two unsigned operands in integer mode never sets `acc_res[39]`.
- R4: When `acc_frac`=0, `acc_res` is the exact product of the two interpreted operands, as a 40-bit two's complement value.
- R5: When `acc_frac`=1, `acc_res` is twice the exact product, which is the Q31 value of two Q15 operands, as 40-bit two's complement. Bit 0 is therefore always 0.
- R6: In fractional mode, 0x8000 times 0x8000 with both operands signed gives `acc_res` = 0x0080000000, which is +1.0 held in the guard bits and not wrapped to a negative value.
- R7: `int_vld` is high in exactly the cycle after each edge that samples `int_go` high, and `int_res` changes only on such edges.
- R8: When `int_byte`=1, only bits 7:0 of each operand are used, and bit 7 is the sign when that operand's sign select is 1. The 16-bit product is placed in `int_res[15:0]`, and `int_res[31:16]` is zero.
- R9: When `int_byte`=0, `int_res` is the exact 32-bit product of the two 16-bit operands for signed×signed, unsigned×unsigned and mixed-sign inputs.
- R10: Both ports may strobe in the same cycle. Each result depends only on its own port's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_go | input | 1 | Strobe for the accumulator-path multiply |
| acc_a | input | 16 | Accumulator-path operand A |
| acc_b | input | 16 | Accumulator-path operand B |
| acc_a_sgn | input | 1 | 1: operand A is signed |
| acc_b_sgn | input | 1 | 1: operand B is signed |
| acc_frac | input | 1 | 1: Q31 fractional result, 0: integer result |
| acc_vld | output | 1 | Accumulator result updated this cycle |
| acc_res | output | 40 | Sign-extended accumulator-path product |
| int_go | input | 1 | Strobe for the integer-port multiply |
| int_byte | input | 1 | 1: byte operands, 0: word operands |
| int_a | input | 16 | Integer-port operand A |
| int_b | input | 16 | Integer-port operand B |
| int_a_sgn | input | 1 | 1: operand A is signed |
| int_b_sgn | input | 1 | 1: operand B is signed |
| int_vld | output | 1 | Integer result updated this cycle |
| int_res | output | 32 | Integer product (byte mode uses bits 15:0) |

## Verification
The accumulator multiply and the integer multiply can be requested in the same cycle, because each port has its own strobe. The bench drives both ports with different operands, signs and modes on every cycle of its vector walk. It then checks each result against a product computed independently from that port's own inputs, so a result that leaks from the other port shows up as a mismatch. Afterwards it drops both strobes and changes every operand, to show that both held results and both valid flags react only to their own strobe.

// File: rtl/dualmode_mul.sv
module dualmode_mul #(
  parameter int W     = 16,
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_go,
  input  logic [W-1:0]     acc_a,
  input  logic [W-1:0]     acc_b,
  input  logic             acc_a_sgn,
  input  logic             acc_b_sgn,
  input  logic             acc_frac,
  output logic             acc_vld,
  output logic [ACC_W-1:0] acc_res,
  input  logic             int_go,
  input  logic             int_byte,
  input  logic [W-1:0]     int_a,
  input  logic [W-1:0]     int_b,
  input  logic             int_a_sgn,
  input  logic             int_b_sgn,
  output logic             int_vld,
  output logic [2*W-1:0]   int_res
);
  localparam int XW = W + 1;
  localparam int PW = 2 * XW;
  localparam int BW = W / 2;
  localparam logic [W-1:0]     MINV  = {1'b1, {(W-1){1'b0}}};
  localparam logic [ACC_W-1:0] Q_ONE = {{(ACC_W-1){1'b0}}, 1'b1} << (2*W-1);

  logic signed [XW-1:0] acc_xa, acc_xb, int_xa, int_xb;
  logic signed [PW-1:0] acc_prod, acc_scaled, int_prod;
  logic [ACC_W-1:0]     acc_nxt;
  logic [2*W-1:0]       int_nxt;

  // one extra top bit carries sign or zero, so one signed array covers all sign mixes
  assign acc_xa = {acc_a_sgn & acc_a[W-1], acc_a};
  assign acc_xb = {acc_b_sgn & acc_b[W-1], acc_b};
  assign acc_prod   = acc_xa * acc_xb;
  assign acc_scaled = acc_frac ? (acc_prod <<< 1) : acc_prod;
  assign acc_nxt    = {{(ACC_W-PW){acc_scaled[PW-1]}}, acc_scaled};

  assign int_xa = int_byte ? {{(XW-BW){int_a_sgn & int_a[BW-1]}}, int_a[BW-1:0]}
                           : {int_a_sgn & int_a[W-1], int_a};
  assign int_xb = int_byte ? {{(XW-BW){int_b_sgn & int_b[BW-1]}}, int_b[BW-1:0]}
                           : {int_b_sgn & int_b[W-1], int_b};
  assign int_prod = int_xa * int_xb;
  assign int_nxt  = int_byte ? {{W{1'b0}}, int_prod[W-1:0]} : int_prod[2*W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_vld <= 1'b0;
      acc_res <= '0;
    end else begin
      acc_vld <= acc_go;
      if (acc_go) acc_res <= acc_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_vld <= 1'b0;
      int_res <= '0;
    end else begin
      int_vld <= int_go;
      if (int_go) int_res <= int_nxt;
    end
  end

  always_comb begin
    if (rst_n) begin
      assert_int_fit_R9: assert (int_prod[PW-1] == int_prod[PW-2]);
    end
  end

  assert_acc_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |=> acc_vld);
  assert_acc_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_go |=> (!acc_vld && $stable(acc_res)));
  assert_uns_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !acc_a_sgn && !acc_b_sgn && !acc_frac) |=> !acc_res[ACC_W-1]);
  assert_frac_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && acc_frac) |=> !acc_res[0]);
  assert_plus_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && acc_frac && acc_a_sgn && acc_b_sgn && acc_a == MINV && acc_b == MINV)
      |=> acc_res == Q_ONE);
  assert_int_vld_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_go |=> int_vld);
  assert_int_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_go |=> (!int_vld && $stable(int_res)));
  assert_byte_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_go && int_byte) |=> int_res[2*W-1:W] == '0);
endmodule

// File: tb/dualmode_mul_tb.sv
`timescale 1ns/1ps
module dualmode_mul_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_go = 1'b0, acc_a_sgn = 1'b0, acc_b_sgn = 1'b0, acc_frac = 1'b0;
  logic [15:0] acc_a = '0, acc_b = '0;
  logic acc_vld;
  logic [39:0] acc_res;
  logic int_go = 1'b0, int_byte = 1'b0, int_a_sgn = 1'b0, int_b_sgn = 1'b0;
  logic [15:0] int_a = '0, int_b = '0;
  logic int_vld;
  logic [31:0] int_res;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dualmode_mul dut_i (
    .clk(clk), .rst_n(rst_n),
    .acc_go(acc_go), .acc_a(acc_a), .acc_b(acc_b),
    .acc_a_sgn(acc_a_sgn), .acc_b_sgn(acc_b_sgn), .acc_frac(acc_frac),
    .acc_vld(acc_vld), .acc_res(acc_res),
    .int_go(int_go), .int_byte(int_byte), .int_a(int_a), .int_b(int_b),
    .int_a_sgn(int_a_sgn), .int_b_sgn(int_b_sgn),
    .int_vld(int_vld), .int_res(int_res)
  );

  // {a, b, a_sgn, b_sgn, frac, expected}
  localparam int NA = 11;
  localparam logic [74:0] ACC_TAB [NA] = '{
    {16'h0003, 16'h0004, 1'b1, 1'b1, 1'b0, 40'h000000000C},
    {16'h4000, 16'h4000, 1'b1, 1'b1, 1'b1, 40'h0020000000},
    {16'hFFFF, 16'h0001, 1'b1, 1'b1, 1'b0, 40'hFFFFFFFFFF},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 40'h00FFFE0001},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 40'hFFFFFF0001},
    {16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, 40'h0080000000},
    {16'h8000, 16'h7FFF, 1'b1, 1'b1, 1'b1, 40'hFF80010000},
    {16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 40'h0040000000},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 40'h01FFFC0002},
    {16'h8000, 16'hFFFF, 1'b0, 1'b1, 1'b0, 40'hFFFFFF8000},
    {16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b1, 40'h007FFE0002}
  };

  // {a, b, a_sgn, b_sgn, byte, expected}
  localparam int NI = 8;
  localparam logic [66:0] INT_TAB [NI] = '{
    {16'hAB80, 16'hCD80, 1'b1, 1'b1, 1'b1, 32'h00004000},
    {16'h12FF, 16'h34FF, 1'b0, 1'b0, 1'b1, 32'h0000FE01},
    {16'h5580, 16'h66FF, 1'b1, 1'b0, 1'b1, 32'h00008080},
    {16'h00FF, 16'h0005, 1'b1, 1'b1, 1'b1, 32'h0000FFFB},
    {16'hFFFE, 16'h0003, 1'b1, 1'b1, 1'b0, 32'hFFFFFFFA},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 32'hFFFE0001},
    {16'h8000, 16'hFFFF, 1'b1, 1'b0, 1'b0, 32'h80008000},
    {16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 32'h40000000}
  };

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 40'd0, 40'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [39:0] held_acc;
    logic [31:0] held_int;
    repeat (3) @(negedge clk);
    chk(acc_res == 0 && !acc_vld, "R1", {acc_vld, acc_res[38:0]}, 40'd0);
    chk(int_res == 0 && !int_vld, "R1", {7'd0, int_vld, int_res}, 40'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(acc_res == 0 && !acc_vld && !int_vld && int_res == 0, "R1",
        {7'd0, acc_vld | int_vld, int_res | acc_res[31:0]}, 40'd0);

    // both ports strobe in the same cycle on every vector (R10)
    for (int i = 0; i < NA; i++) begin
      {acc_a, acc_b, acc_a_sgn, acc_b_sgn, acc_frac} = ACC_TAB[i][74:40];
      {int_a, int_b, int_a_sgn, int_b_sgn, int_byte} = INT_TAB[i % NI][66:32];
      acc_go = 1'b1;
      int_go = 1'b1;
      @(negedge clk);
      chk(acc_vld == 1'b1, "R2", {39'd0, acc_vld}, 40'd1);
      chk(acc_res == ACC_TAB[i][39:0],
          ACC_TAB[i][40] ? "R5/R6 frac product R10" : "R3/R4 int product R10",
          acc_res, ACC_TAB[i][39:0]);
      chk(int_vld == 1'b1, "R7", {39'd0, int_vld}, 40'd1);
      chk(int_res == INT_TAB[i % NI][31:0],
          INT_TAB[i % NI][32] ? "R8 byte product R10" : "R9 word product R10",
          {8'd0, int_res}, {8'd0, INT_TAB[i % NI][31:0]});
    end

    // hold: strobes low, every operand and mode changed
    held_acc = acc_res;
    held_int = int_res;
    acc_go = 1'b0; int_go = 1'b0;
    acc_a = 16'h1234; acc_b = 16'h5678; acc_frac = 1'b0;
    int_a = 16'h0F0F; int_b = 16'h7777; int_byte = 1'b0;
    @(negedge clk);
    chk(!acc_vld && acc_res == held_acc, "R2 hold", acc_res, held_acc);
    chk(!int_vld && int_res == held_int, "R7 hold", {8'd0, int_res}, {8'd0, held_int});
    repeat (3) @(negedge clk);
    chk(acc_res == held_acc, "R2 hold", acc_res, held_acc);
    chk(int_res == held_int, "R7 hold", {8'd0, int_res}, {8'd0, held_int});

    // only the integer port strobes: accumulator result stays (R10)
    int_go = 1'b1; int_byte = 1'b1; int_a_sgn = 1'b0; int_b_sgn = 1'b0;
    int_a = 16'hFF02; int_b = 16'hEE03;
    @(negedge clk);
    int_go = 1'b0;
    chk(int_res == 32'h00000006, "R8 upper bits ignored", {8'd0, int_res}, 40'h6);
    chk(!acc_vld && acc_res == held_acc, "R10 isolation", acc_res, held_acc);

    // single-cycle strobe: valid for one cycle only
    acc_go = 1'b1; acc_a = 16'h0002; acc_b = 16'hFFFD; acc_a_sgn = 1'b0;
    acc_b_sgn = 1'b1; acc_frac = 1'b1;
    @(negedge clk);
    acc_go = 1'b0;
    chk(acc_vld && acc_res == 40'hFFFFFFFFF4, "R5 mixed frac", acc_res, 40'hFFFFFFFFF4);
    @(negedge clk);
    chk(!acc_vld, "R2 one pulse", {39'd0, acc_vld}, 40'd0);

    // reset mid-run clears both results
    rst_n = 1'b0;
    @(negedge clk);
    chk(acc_res == 0 && int_res == 0 && !acc_vld && !int_vld, "R1 reset",
        acc_res | {8'd0, int_res}, 40'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule